// File: doc/BRIEF.md
# Two-Antenna Space-Time Block Combiner with QPSK Decision

This block sits behind a receiver that sees a two-transmit, two-receive space-time block code. Each code block spans two symbol periods. In the first period the block captures one complex sample from each of its two receive antennas. In the second period it takes the next pair of samples together with the four complex channel gains, one for each transmit/receive antenna pair. The gains are treated as exact, and as flat and unchanged across the two periods.

From these inputs it builds two combined estimates with conjugate-weighted complex products. The first-symbol estimate is the sum over receive antennas j of conj(g_0j)·x_j(first) + g_1j·conj(x_j(second)). The second-symbol estimate is the sum of conj(g_1j)·x_j(first) − g_0j·conj(x_j(second)). Here g_ij is the gain from transmit antenna i to receive antenna j.

Each estimate is then mapped to the nearest QPSK point. Scaling by the total channel power does not change which point is nearest, so only the signs of the real and imaginary parts are used. Samples and gains are signed fixed point, SAMPLE_W bits wide with FRAC_W fraction bits. The datapath is a three-stage pipeline: complex products, saturating sum, decision.

Top module: `stbc_pair_detector`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both valid outputs are low. A block whose second period was accepted before or during reset produces no output. Both symbol indices reset to 0.
- R2: A second-period input (`in_valid`=1, `in_second`=1) sampled at rising edge E makes `sym0_valid` and `sym1_valid` high together for exactly the one cycle that follows edge E+2. Blocks may be issued on back-to-back cycles.
- R3: A first-period input (`in_valid`=1, `in_second`=0) stores both antenna samples. They stay stored across any number of idle cycles until the next first-period input.
- R4: The first-symbol estimate is the sum over j of conj(g_0j)·x_j(first) + g_1j·conj(x_j(second)).
- R5: The second-symbol estimate is the sum over j of conj(g_1j)·x_j(first) − g_0j·conj(x_j(second)).
- R6: The QPSK index is {imag part negative, real part negative}: bit 0 is set when the real part is below zero, and bit 1 when the imaginary part is below zero. A part equal to zero counts as non-negative, so an all-zero estimate gives index 0.
- R7: Each complex product is rounded (add half an LSB, then arithmetic shift right by FRAC_W) back to SAMPLE_W bits. It saturates to the largest or smallest SAMPLE_W value rather than wrapping.
- R8: The four-term sum for each part of each estimate saturates to SAMPLE_W bits rather than wrapping.
- R9: The channel gain inputs are used only in the second-period cycle. Their values during first-period and idle cycles have no effect.
- R10: Between valid pulses, both symbol indices hold the last decision.
- R11: A cycle with `in_valid` low neither stores samples nor starts a block, whatever `in_second` and the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair present this cycle |
| in_second | input | 1 | 0: first period of the block, 1: second period |
| rx0_re | input | SAMPLE_W | Antenna 0 sample, real |
| rx0_im | input | SAMPLE_W | Antenna 0 sample, imaginary |
| rx1_re | input | SAMPLE_W | Antenna 1 sample, real |
| rx1_im | input | SAMPLE_W | Antenna 1 sample, imaginary |
| gain_t0r0_re | input | SAMPLE_W | Gain transmit 0 to receive 0, real |
| gain_t0r0_im | input | SAMPLE_W | Gain transmit 0 to receive 0, imaginary |
| gain_t0r1_re | input | SAMPLE_W | Gain transmit 0 to receive 1, real |
| gain_t0r1_im | input | SAMPLE_W | Gain transmit 0 to receive 1, imaginary |
| gain_t1r0_re | input | SAMPLE_W | Gain transmit 1 to receive 0, real |
| gain_t1r0_im | input | SAMPLE_W | Gain transmit 1 to receive 0, imaginary |
| gain_t1r1_re | input | SAMPLE_W | Gain transmit 1 to receive 1, real |
| gain_t1r1_im | input | SAMPLE_W | Gain transmit 1 to receive 1, imaginary |
| sym0_idx | output | 2 | First-symbol QPSK index |
| sym0_valid | output | 1 | First-symbol decision valid |
| sym1_idx | output | 2 | Second-symbol QPSK index |
| sym1_valid | output | 1 | Second-symbol decision valid |

## Verification
Noise-free blocks are encoded in the bench from known symbol pairs. Three channel types are used. An identity channel exercises all sixteen symbol pairs back to back and separates the index bit mapping. Random complex channels with every cross gain non-zero catch a swapped gain, a missing conjugate or a wrong sign in either combining formula. Hand-built samples near full scale tell saturation apart from wrap-around, first in a single product and then in the sum. Junk on the gain and sample inputs during idle and first-period cycles, long gaps between periods, and a reset in mid-pipeline show that only qualified inputs are used.

// File: rtl/stbc_pkg.sv
package stbc_pkg;
  localparam int NUM_ANT       = 2;
  localparam int TERMS_PER_SYM = 2 * NUM_ANT;
  localparam int NUM_PROD      = 2 * TERMS_PER_SYM;

  typedef struct packed {
    logic conj_a;
    logic conj_b;
    logic negate;
  } cmul_mode_t;

  function automatic logic [1:0] qpsk_index(input logic re_neg, input logic im_neg);
    return {im_neg, re_neg};
  endfunction
endpackage

// File: rtl/stbc_cmul.sv
module stbc_cmul
  import stbc_pkg::*;
#(
  parameter int W    = 12,
  parameter int FRAC = 10
) (
  input  logic                clk,
  input  logic                en,
  input  cmul_mode_t          mode,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic signed [W-1:0] p_re,
  output logic signed [W-1:0] p_im
);
  localparam int PW = 2 * W + 3;
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [W:0]    xa_re, xa_im, xb_re, xb_im;
  logic signed [PW-1:0] raw_re, raw_im, adj_re, adj_im, rnd_re, rnd_im;

  function automatic logic signed [W-1:0] clip(input logic signed [PW-1:0] v);
    if (v > MAXV)      return MAXV[W-1:0];
    else if (v < MINV) return MINV[W-1:0];
    else               return v[W-1:0];
  endfunction

  always_comb begin
    xa_re  = {a_re[W-1], a_re};
    xb_re  = {b_re[W-1], b_re};
    xa_im  = mode.conj_a ? -{a_im[W-1], a_im} : {a_im[W-1], a_im};
    xb_im  = mode.conj_b ? -{b_im[W-1], b_im} : {b_im[W-1], b_im};
    raw_re = PW'(xa_re) * PW'(xb_re) - PW'(xa_im) * PW'(xb_im);
    raw_im = PW'(xa_re) * PW'(xb_im) + PW'(xa_im) * PW'(xb_re);
    adj_re = mode.negate ? -raw_re : raw_re;
    adj_im = mode.negate ? -raw_im : raw_im;
    rnd_re = (adj_re + RND) >>> FRAC;
    rnd_im = (adj_im + RND) >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      p_re <= clip(rnd_re);
      p_im <= clip(rnd_im);
    end
  end
endmodule

// File: rtl/stbc_sat_sum.sv
module stbc_sat_sum #(
  parameter int W = 12,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                en,
  input  logic signed [W-1:0] terms [N],
  output logic signed [W-1:0] total
);
  localparam int SW = W + $clog2(N) + 1;
  localparam logic signed [SW-1:0] MAXV = (SW'(1) <<< (W - 1)) - SW'(1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  logic signed [SW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + SW'(terms[i]);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (acc > MAXV)      total <= MAXV[W-1:0];
      else if (acc < MINV) total <= MINV[W-1:0];
      else                 total <= acc[W-1:0];
    end
  end
endmodule

// File: rtl/stbc_qpsk_slicer.sv
module stbc_qpsk_slicer
  import stbc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] est_re,
  input  logic signed [W-1:0] est_im,
  output logic [1:0]          idx
);
  always_ff @(posedge clk) begin
    if (rst)     idx <= 2'd0;
    else if (en) idx <= qpsk_index(est_re[W-1], est_im[W-1]);
  end
endmodule

// File: rtl/stbc_pair_detector.sv
module stbc_pair_detector
  import stbc_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FRAC_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_second,
  input  logic signed [SAMPLE_W-1:0] rx0_re,
  input  logic signed [SAMPLE_W-1:0] rx0_im,
  input  logic signed [SAMPLE_W-1:0] rx1_re,
  input  logic signed [SAMPLE_W-1:0] rx1_im,
  input  logic signed [SAMPLE_W-1:0] gain_t0r0_re,
  input  logic signed [SAMPLE_W-1:0] gain_t0r0_im,
  input  logic signed [SAMPLE_W-1:0] gain_t0r1_re,
  input  logic signed [SAMPLE_W-1:0] gain_t0r1_im,
  input  logic signed [SAMPLE_W-1:0] gain_t1r0_re,
  input  logic signed [SAMPLE_W-1:0] gain_t1r0_im,
  input  logic signed [SAMPLE_W-1:0] gain_t1r1_re,
  input  logic signed [SAMPLE_W-1:0] gain_t1r1_im,
  output logic [1:0]                 sym0_idx,
  output logic                       sym0_valid,
  output logic [1:0]                 sym1_idx,
  output logic                       sym1_valid
);
  localparam int W = SAMPLE_W;

  logic signed [W-1:0] rx_re   [NUM_ANT];
  logic signed [W-1:0] rx_im   [NUM_ANT];
  logic signed [W-1:0] hold_re [NUM_ANT];
  logic signed [W-1:0] hold_im [NUM_ANT];
  logic signed [W-1:0] g_re    [NUM_ANT][NUM_ANT];
  logic signed [W-1:0] g_im    [NUM_ANT][NUM_ANT];
  logic signed [W-1:0] pr_re   [NUM_PROD];
  logic signed [W-1:0] pr_im   [NUM_PROD];
  logic signed [W-1:0] est_re  [2];
  logic signed [W-1:0] est_im  [2];
  logic [1:0]          idx     [2];

  logic capture, fire, v_prod, v_sum, v_out;

  assign rx_re[0] = rx0_re;  assign rx_im[0] = rx0_im;
  assign rx_re[1] = rx1_re;  assign rx_im[1] = rx1_im;
  assign g_re[0][0] = gain_t0r0_re;  assign g_im[0][0] = gain_t0r0_im;
  assign g_re[0][1] = gain_t0r1_re;  assign g_im[0][1] = gain_t0r1_im;
  assign g_re[1][0] = gain_t1r0_re;  assign g_im[1][0] = gain_t1r0_im;
  assign g_re[1][1] = gain_t1r1_re;  assign g_im[1][1] = gain_t1r1_im;

  assign capture = in_valid && !in_second;
  assign fire    = in_valid && in_second;

  // first-period storage
  always_ff @(posedge clk) begin
    if (capture) begin
      for (int j = 0; j < NUM_ANT; j++) begin
        hold_re[j] <= rx_re[j];
        hold_im[j] <= rx_im[j];
      end
    end
  end

  // eight products: k = sym*4 + rx*2 + late
  for (genvar k = 0; k < NUM_PROD; k++) begin : g_prod
    localparam int SYM  = k / TERMS_PER_SYM;
    localparam int RX   = (k / 2) % NUM_ANT;
    localparam int LATE = k % 2;
    localparam int TX   = SYM ^ LATE;
    localparam cmul_mode_t MODE = '{conj_a: (LATE == 0), conj_b: (LATE == 1),
                                    negate: (SYM == 1 && LATE == 1)};
    logic signed [W-1:0] b_re, b_im;
    assign b_re = (LATE == 1) ? rx_re[RX] : hold_re[RX];
    assign b_im = (LATE == 1) ? rx_im[RX] : hold_im[RX];

    stbc_cmul #(.W(W), .FRAC(FRAC_W)) u_mul (
      .clk (clk),
      .en  (fire),
      .mode(MODE),
      .a_re(g_re[TX][RX]),
      .a_im(g_im[TX][RX]),
      .b_re(b_re),
      .b_im(b_im),
      .p_re(pr_re[k]),
      .p_im(pr_im[k])
    );
  end

  for (genvar s = 0; s < 2; s++) begin : g_sym
    logic signed [W-1:0] t_re [TERMS_PER_SYM];
    logic signed [W-1:0] t_im [TERMS_PER_SYM];
    for (genvar i = 0; i < TERMS_PER_SYM; i++) begin : g_term
      assign t_re[i] = pr_re[s * TERMS_PER_SYM + i];
      assign t_im[i] = pr_im[s * TERMS_PER_SYM + i];
    end

    stbc_sat_sum #(.W(W), .N(TERMS_PER_SYM)) u_sum_re (
      .clk(clk), .en(v_prod), .terms(t_re), .total(est_re[s]));
    stbc_sat_sum #(.W(W), .N(TERMS_PER_SYM)) u_sum_im (
      .clk(clk), .en(v_prod), .terms(t_im), .total(est_im[s]));

    stbc_qpsk_slicer #(.W(W)) u_slice (
      .clk(clk), .rst(rst), .en(v_sum),
      .est_re(est_re[s]), .est_im(est_im[s]), .idx(idx[s]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_prod <= 1'b0;
      v_sum  <= 1'b0;
      v_out  <= 1'b0;
    end else begin
      v_prod <= fire;
      v_sum  <= v_prod;
      v_out  <= v_sum;
    end
  end

  assign sym0_idx   = idx[0];
  assign sym1_idx   = idx[1];
  assign sym0_valid = v_out;
  assign sym1_valid = v_out;
endmodule

// File: rtl/stbc_pair_detector_chk.sv
module stbc_pair_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_second,
  input logic [1:0] sym0_idx,
  input logic       sym0_valid,
  input logic [1:0] sym1_idx,
  input logic       sym1_valid
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!sym0_valid && !sym1_valid)); // R1

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_second) |-> ##3 (sym0_valid && sym1_valid)); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    sym0_valid |-> $past(in_valid && in_second, 3)); // R11

  AST_HOLD_IDX0: assert property (@(posedge clk) disable iff (rst)
    !sym0_valid |-> $stable(sym0_idx)); // R10

  AST_HOLD_IDX1: assert property (@(posedge clk) disable iff (rst)
    !sym1_valid |-> $stable(sym1_idx)); // R10
endmodule

bind stbc_pair_detector stbc_pair_detector_chk i_chk (.*);

// File: tb/test_stbc_pair_detector.sv
`timescale 1ns/1ps
module test_stbc_pair_detector;
  localparam int SW = 12;
  localparam int AMP = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_second = 1'b0;
  logic signed [SW-1:0] rx0_re = '0, rx0_im = '0, rx1_re = '0, rx1_im = '0;
  logic signed [SW-1:0] g00r = '0, g00i = '0, g01r = '0, g01i = '0;
  logic signed [SW-1:0] g10r = '0, g10i = '0, g11r = '0, g11i = '0;
  logic [1:0] sym0_idx, sym1_idx;
  logic sym0_valid, sym1_valid;

  int total = 0, bad = 0;
  int hr [2][2], hi [2][2];
  int fr_re [2], fr_im [2], sr_re [2], sr_im [2];
  int cap0 [64], cap1 [64], exp0 [64], exp1 [64];
  int ncap = 0, nexp = 0;

  always #2 clk = ~clk;

  stbc_pair_detector i_stbc_pair_detector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_second(in_second),
    .rx0_re(rx0_re), .rx0_im(rx0_im), .rx1_re(rx1_re), .rx1_im(rx1_im),
    .gain_t0r0_re(g00r), .gain_t0r0_im(g00i), .gain_t0r1_re(g01r), .gain_t0r1_im(g01i),
    .gain_t1r0_re(g10r), .gain_t1r0_im(g10i), .gain_t1r1_re(g11r), .gain_t1r1_im(g11i),
    .sym0_idx(sym0_idx), .sym0_valid(sym0_valid), .sym1_idx(sym1_idx), .sym1_valid(sym1_valid));

  always @(negedge clk) begin
    if (sym0_valid || sym1_valid) begin
      if (ncap < 64) begin
        cap0[ncap] = int'(sym0_idx);
        cap1[ncap] = int'(sym1_idx);
      end
      ncap = ncap + 1;
      total = total + 1;
      if (sym0_valid != sym1_valid) begin
        bad = bad + 1;
        $display("FAIL R2 valid pair mismatch: act=%0d exp=%0d", sym1_valid, sym0_valid);
      end
    end
  end

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    bad = bad + 1;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    report();
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int rnd_gain();
    int m = int'($urandom_range(449, 150));
    return ($urandom_range(1, 0) == 1) ? -m : m;
  endfunction

  function automatic int junk();
    return int'($urandom_range(4095, 0)) - 2048;
  endfunction

  task automatic apply_gains(input bit use_junk);
    g00r = SW'(use_junk ? junk() : hr[0][0]);  g00i = SW'(use_junk ? junk() : hi[0][0]);
    g01r = SW'(use_junk ? junk() : hr[0][1]);  g01i = SW'(use_junk ? junk() : hi[0][1]);
    g10r = SW'(use_junk ? junk() : hr[1][0]);  g10i = SW'(use_junk ? junk() : hi[1][0]);
    g11r = SW'(use_junk ? junk() : hr[1][1]);  g11i = SW'(use_junk ? junk() : hi[1][1]);
  endtask

  // noise-free two-antenna block code built from symbol indices (R6 mapping)
  task automatic encode(input int s0, input int s1);
    int a_re = (s0 % 2 == 1) ? -AMP : AMP;
    int a_im = (s0 / 2 == 1) ? -AMP : AMP;
    int b_re = (s1 % 2 == 1) ? -AMP : AMP;
    int b_im = (s1 / 2 == 1) ? -AMP : AMP;
    for (int j = 0; j < 2; j++) begin
      fr_re[j] = (hr[0][j]*a_re - hi[0][j]*a_im + hr[1][j]*b_re - hi[1][j]*b_im) / 1024;
      fr_im[j] = (hr[0][j]*a_im + hi[0][j]*a_re + hr[1][j]*b_im + hi[1][j]*b_re) / 1024;
      sr_re[j] = (-(hr[0][j]*b_re + hi[0][j]*b_im) + hr[1][j]*a_re + hi[1][j]*a_im) / 1024;
      sr_im[j] = (-(hi[0][j]*b_re - hr[0][j]*b_im) + hi[1][j]*a_re - hr[1][j]*a_im) / 1024;
    end
  endtask

  task automatic send(input int gap, input bit junk_first, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_second = 1'b0;
    rx0_re = SW'(fr_re[0]); rx0_im = SW'(fr_im[0]);
    rx1_re = SW'(fr_re[1]); rx1_im = SW'(fr_im[1]);
    apply_gains(junk_first);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0; in_second = ($urandom_range(1, 0) == 1);
      rx0_re = SW'(junk()); rx0_im = SW'(junk());
      rx1_re = SW'(junk()); rx1_im = SW'(junk());
      apply_gains(1'b1);
    end
    @(negedge clk);
    in_valid = 1'b1; in_second = 1'b1;
    rx0_re = SW'(sr_re[0]); rx0_im = SW'(sr_im[0]);
    rx1_re = SW'(sr_re[1]); rx1_im = SW'(sr_im[1]);
    apply_gains(1'b0);
    if (last) begin
      @(negedge clk);
      in_valid = 1'b0; in_second = 1'b0;
    end
  endtask

  task automatic expect_pair(input int s0, input int s1);
    exp0[nexp] = s0; exp1[nexp] = s1; nexp = nexp + 1;
  endtask

  task automatic compare_burst(input string req);
    repeat (6) @(negedge clk);
    chk(ncap == nexp, {req, " decision count"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      chk(cap0[i] == exp0[i], {req, " first symbol"}, cap0[i], exp0[i]);
      chk(cap1[i] == exp1[i], {req, " second symbol"}, cap1[i], exp1[i]);
    end
    ncap = 0; nexp = 0;
  endtask

  task automatic set_identity();
    hr[0][0] = 1024; hi[0][0] = 0; hr[1][1] = 1024; hi[1][1] = 0;
    hr[0][1] = 0; hi[0][1] = 0; hr[1][0] = 0; hi[1][0] = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!sym0_valid && !sym1_valid, "R1 valid during reset", int'(sym0_valid), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!sym0_valid && !sym1_valid, "R1 valid after reset", int'(sym1_valid), 0);
    chk(sym0_idx == 2'd0 && sym1_idx == 2'd0, "R1 reset index",
        int'({sym1_idx, sym0_idx}), 0);
    ncap = 0;
  endtask

  // R4 R5 R6: all sixteen pairs on an identity channel, back to back
  task automatic t_identity_sweep();
    set_identity();
    for (int p = 0; p < 16; p++) begin
      encode(p % 4, p / 4);
      send(0, 1'b0, p == 15);
      expect_pair(p % 4, p / 4);
    end
    compare_burst("R6 R2 identity sweep");
  endtask

  task automatic t_latency();
    set_identity();
    encode(2, 1);
    ncap = 0;
    send(0, 1'b0, 1'b1);
    @(posedge clk); #1;
    chk(!sym0_valid, "R2 early valid", int'(sym0_valid), 0);
    @(posedge clk); #1;
    chk(sym0_valid && sym1_valid, "R2 valid at latency", int'(sym0_valid), 1);
    chk(sym0_idx == 2'd2 && sym1_idx == 2'd1, "R2 R6 latency indices",
        int'({sym1_idx, sym0_idx}), 6);
    @(posedge clk); #1;
    chk(!sym0_valid, "R2 single cycle pulse", int'(sym0_valid), 0);
    ncap = 0;
  endtask

  // R4 R5 R3 R9 R11: random channels, idle gaps with junk, junk gains in period one
  task automatic t_random_channels();
    for (int b = 0; b < 40; b++) begin
      for (int t = 0; t < 2; t++)
        for (int r = 0; r < 2; r++) begin
          hr[t][r] = rnd_gain(); hi[t][r] = rnd_gain();
        end
      begin
        int s0 = int'($urandom_range(3, 0));
        int s1 = int'($urandom_range(3, 0));
        encode(s0, s1);
        send(int'($urandom_range(3, 0)), 1'b1, 1'b1);
        expect_pair(s0, s1);
      end
      if (nexp == 20) compare_burst("R4 R5 R9 random channel");
    end
    compare_burst("R3 R11 random channel with gaps");
  endtask

  task automatic drive_raw(input int f0, input int f1, input int s0v, input int s1v);
    fr_re[0] = f0; fr_im[0] = 0; fr_re[1] = f1; fr_im[1] = 0;
    sr_re[0] = s0v; sr_im[0] = 0; sr_re[1] = s1v; sr_im[1] = 0;
    send(0, 1'b0, 1'b1);
  endtask

  task automatic t_saturation();
    hr = '{'{0, 0}, '{0, 0}}; hi = '{'{0, 0}, '{0, 0}};
    hr[0][0] = 2047;
    drive_raw(2047, 0, 0, 0);   expect_pair(0, 0);   // R7 product clips high
    drive_raw(-2048, 0, 0, 0);  expect_pair(1, 0);   // R7 product clips low
    compare_burst("R7 product saturation");
    hr[0][0] = 1126; hr[0][1] = 1126;
    drive_raw(1126, 1126, 0, 0);    expect_pair(0, 0); // R8 sum clips high
    drive_raw(-1126, -1126, 0, 0);  expect_pair(1, 0); // R8 sum clips low
    compare_burst("R8 sum saturation");
    drive_raw(0, 0, 0, 0);          expect_pair(0, 0); // R6 zero tie
    compare_burst("R6 zero estimate");
  endtask

  task automatic t_hold_and_idle();
    int h0, h1;
    set_identity();
    encode(3, 2);
    send(0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    h0 = int'(sym0_idx); h1 = int'(sym1_idx);
    chk(h0 == 3 && h1 == 2, "R10 decision present", h0 * 4 + h1, 14);
    ncap = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      in_valid = 1'b0; in_second = (c % 2 == 1);
      rx0_re = SW'(junk()); rx1_re = SW'(junk());
      apply_gains(1'b1);
    end
    repeat (4) @(negedge clk);
    chk(ncap == 0, "R11 no decision without in_valid", ncap, 0);
    chk(int'(sym0_idx) == h0 && int'(sym1_idx) == h1, "R10 index held",
        int'({sym1_idx, sym0_idx}), h1 * 4 + h0);
  endtask

  task automatic t_reset_midflight();
    set_identity();
    encode(1, 3);
    ncap = 0;
    send(0, 1'b0, 1'b1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(ncap == 0, "R1 reset drops block in flight", ncap, 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_identity_sweep();
    t_random_channels();
    t_saturation();
    t_hold_and_idle();
    t_reset_midflight();
    report();
  end
endmodule